// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a configuration image into an FPGA through its slave-serial port. The image arrives as a byte stream over a valid/ready handshake, and a start pulse supplies its total length in bytes. The loader first clears the target with a low pulse on the program line and waits for the target to erase itself. Before any data is sent, the done line must read low. Any header bytes that come before the first 0xFF byte are consumed and dropped. The loader then serialises the remaining bytes onto the data line, one bit per configuration clock, and adds a fixed number of extra clocks at the end. After a final settling wait it samples the done line and reports either success or error.

While bytes stream past, the loader also builds a short text identifier from two fixed windows in the image: a name field and a date field. The identifier is delivered as a sequence of bytes on a separate valid strobe. The delays, the width of the clock phases and the window positions are all parameters, counted in system clock cycles.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and whenever the block is idle, cfg_prog_n is 1, cfg_cclk is 0, cfg_din is 0, and in_ready is 0. After reset, busy, ok and err are all 0.
- R2: A start taken while idle drives cfg_prog_n low for PROG_CYC cycles and then releases it. After a further CLEAR_CYC cycles the synchronised cfg_done is checked. If cfg_done is high at that point, the block sets err, accepts no byte and issues no cfg_cclk pulse.
- R3: Bytes that precede the first byte equal to 0xFF are consumed and not shifted out. That 0xFF byte is the first one shifted. Every later byte up to img_len is shifted, including any further 0xFF bytes.
- R4: Each byte is shifted most significant bit first. cfg_din holds the bit for at least one cycle before cfg_cclk rises and stays unchanged while cfg_cclk is high. High phases last HI_CYC cycles and low phases last LO_CYC cycles.
- R5: After the last data bit, exactly TAIL_PULSES (default 5) further cfg_cclk pulses are issued, with cfg_din held at the last data bit.
- R6: SETTLE_CYC cycles after the last trailing pulse, a high cfg_done sets ok and a low cfg_done sets err.
- R7: If no 0xFF byte occurs within img_len bytes, the block consumes all img_len bytes, issues no cfg_cclk pulse and sets err.
- R8: Each byte is transferred exactly once, on a cycle where in_valid and in_ready are both 1. No byte is requested beyond img_len. While the block waits for a byte, cfg_cclk stays low.
- R9: ok and err are never 1 together. Both hold their value until the next accepted start, which clears them. A start received while busy is ignored.
- R10: The identifier is emitted as id_data bytes qualified by id_valid, one per accepted image byte, in this order:
  - Name bytes come from offsets NAME_OFS (0x10) through NAME_OFS+11. A 0x00 byte there ends the name and is emitted as a space (0x20). If the name fills all 12 bytes, the space is emitted when offset NAME_OFS+12 arrives.
  - Date bytes come from offsets DATE_OFS (0x2C) through DATE_OFS+9. A 0x00 byte there ends the date and is emitted as the 0x00 terminator. If the date fills all 10 bytes, the terminator is emitted when offset DATE_OFS+10 arrives.
  - Offsets at or beyond img_len produce nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| img_len | input | LEN_W | Image length in bytes, sampled at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program line to target |
| cfg_cclk | output | 1 | Configuration clock to target |
| cfg_din | output | 1 | Serial configuration data to target |
| cfg_done | input | 1 | Done line from target (asynchronous) |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load succeeded (sticky) |
| err | output | 1 | Last load failed (sticky) |
| id_data | output | 8 | Identifier byte |
| id_valid | output | 1 | id_data is valid this cycle |

## Verification
The bench feeds several kinds of image:
- a 0xFF sync byte placed after the identifier windows, inside the name window, and at offset zero;
- an image with no sync byte at all;
- a target whose done line stays high after the clear step;
- a target that never raises done.

A loader that counted the sync byte as header would lose its first eight bits. One that shifted least significant bit first, or changed the data line at the clock edge, would give a mismatch at the rising edge of the very next pulse. An image with no sync byte shows whether the loader clocks data it never found, and a done line stuck high shows whether bytes were taken after a failed clear check. The bench stalls in_valid on a regular pattern and injects a start in the middle of a load, which exposes dropped or repeated bytes, a clock that runs while waiting, and a restart on a spurious start. It also checks a full 12-byte name with a short date, and a short name with a full date, so both the early and the late placement of the space and of the terminator are covered.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int LEN_W       = 16,
  parameter int PROG_CYC    = 2,
  parameter int CLEAR_CYC   = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int HI_CYC      = 2,
  parameter int LO_CYC      = 2,
  parameter int TAIL_PULSES = 5,
  parameter int NAME_OFS    = 16,
  parameter int NAME_MAX    = 12,
  parameter int DATE_OFS    = 44,
  parameter int DATE_MAX    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             cfg_prog_n,
  output logic             cfg_cclk,
  output logic             cfg_din,
  input  logic             cfg_done,
  output logic             busy,
  output logic             ok,
  output logic             err,
  output logic [7:0]       id_data,
  output logic             id_valid
);
  localparam int CW = $clog2(PROG_CYC + CLEAR_CYC + SETTLE_CYC + HI_CYC + LO_CYC + 1);
  localparam int TW = $clog2(TAIL_PULSES + 1);
  localparam logic [7:0] SYNC = 8'hFF;
  localparam logic [LEN_W-1:0] NAME_LO  = LEN_W'(NAME_OFS);
  localparam logic [LEN_W-1:0] NAME_END = LEN_W'(NAME_OFS + NAME_MAX);
  localparam logic [LEN_W-1:0] DATE_LO  = LEN_W'(DATE_OFS);
  localparam logic [LEN_W-1:0] DATE_END = LEN_W'(DATE_OFS + DATE_MAX);

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_CLEAR, S_SKIP, S_SET, S_HI, S_LO, S_FETCH, S_SETTLE
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] left, off;
  logic [7:0]       sh;
  logic [2:0]       bits;
  logic [TW-1:0]    tcnt;
  logic             tail, done_m, done_s, name_stop, date_stop;

  wire fire  = in_valid & in_ready;
  wire cnt_z = (cnt == '0);

  assign in_ready   = (st == S_SKIP || st == S_FETCH) && (left != '0);
  assign busy       = (st != S_IDLE);
  assign cfg_prog_n = (st != S_PROG);
  assign cfg_cclk   = (st == S_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_m <= 1'b0;
      done_s <= 1'b0;
    end else begin
      done_m <= cfg_done;
      done_s <= done_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; left <= '0; off <= '0; sh <= '0; bits <= '0;
      tcnt <= '0; tail <= 1'b0; cfg_din <= 1'b0; ok <= 1'b0; err <= 1'b0;
    end else begin
      if (fire) begin
        left <= left - 1'b1;
        off  <= off + 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          st <= S_PROG; cnt <= CW'(PROG_CYC - 1); left <= img_len; off <= '0;
          ok <= 1'b0; err <= 1'b0; tail <= 1'b0; cfg_din <= 1'b0;
        end
        S_PROG: if (cnt_z) begin
          st <= S_CLEAR; cnt <= CW'(CLEAR_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_CLEAR: if (!cnt_z) cnt <= cnt - 1'b1;
          else if (done_s) begin err <= 1'b1; st <= S_IDLE; end
          else st <= S_SKIP;
        S_SKIP: if (left == '0) begin
          err <= 1'b1; st <= S_IDLE;
        end else if (fire && in_data == SYNC) begin
          sh <= in_data; cfg_din <= 1'b1; bits <= 3'd7; st <= S_SET;
        end
        S_SET: begin
          st <= S_HI; cnt <= CW'(HI_CYC - 1);
        end
        S_HI: if (cnt_z) begin
          st <= S_LO; cnt <= CW'(LO_CYC - 1);
          if (!tail) sh <= {sh[6:0], 1'b0};
        end else cnt <= cnt - 1'b1;
        S_LO: if (!cnt_z) cnt <= cnt - 1'b1;
          else if (tail) begin
            if (tcnt == '0) begin st <= S_SETTLE; cnt <= CW'(SETTLE_CYC - 1); end
            else begin tcnt <= tcnt - 1'b1; st <= S_HI; cnt <= CW'(HI_CYC - 1); end
          end else if (bits != '0) begin
            bits <= bits - 1'b1; cfg_din <= sh[7]; st <= S_SET;
          end else st <= S_FETCH;
        S_FETCH: if (left == '0) begin
          tail <= 1'b1; tcnt <= TW'(TAIL_PULSES - 1); st <= S_HI; cnt <= CW'(HI_CYC - 1);
        end else if (fire) begin
          sh <= in_data; cfg_din <= in_data[7]; bits <= 3'd7; st <= S_SET;
        end
        S_SETTLE: if (!cnt_z) cnt <= cnt - 1'b1;
          else begin
            ok <= done_s; err <= !done_s; cfg_din <= 1'b0; st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_valid <= 1'b0; id_data <= '0; name_stop <= 1'b0; date_stop <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      if (start && st == S_IDLE) begin
        name_stop <= 1'b0;
        date_stop <= 1'b0;
      end else if (fire) begin
        if (!name_stop && off >= NAME_LO && off < NAME_END) begin
          id_valid <= 1'b1;
          if (in_data == 8'h00) begin id_data <= 8'h20; name_stop <= 1'b1; end
          else id_data <= in_data;
        end else if (!name_stop && off == NAME_END) begin
          id_valid <= 1'b1; id_data <= 8'h20; name_stop <= 1'b1;
        end else if (!date_stop && off >= DATE_LO && off < DATE_END) begin
          id_valid <= 1'b1; id_data <= in_data;
          if (in_data == 8'h00) date_stop <= 1'b1;
        end else if (!date_stop && off == DATE_END) begin
          id_valid <= 1'b1; id_data <= 8'h00; date_stop <= 1'b1;
        end
      end
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cfg_prog_n && !cfg_cclk && !cfg_din && !in_ready));
  assert_no_clk_in_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_cclk);
  assert_din_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_din));
  assert_din_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));
  assert_wait_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cfg_cclk);
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));
  assert_ok_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ok) && !$past(start)) |-> ok);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && !$past(start)) |-> err);
endmodule

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
  localparam int PROG_CYC = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, cfg_done = 1'b1;
  logic [15:0] img_len = '0;
  logic [7:0]  in_data = '0;
  wire in_ready, cfg_prog_n, cfg_cclk, cfg_din, busy, ok, err, id_valid;
  wire [7:0] id_data;

  cfg_serial_loader u_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
    .cfg_done(cfg_done), .busy(busy), .ok(ok), .err(err),
    .id_data(id_data), .id_valid(id_valid));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] img [0:511];
  logic       exp_bits[$];
  logic [7:0] exp_id[$];
  int  pulses = 0, exp_pulses = 0, done_mode = 0, prog_lo = 0, cyc_total = 0;
  logic cclk_q = 1'b0;

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: target model and scoreboard compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_cclk && !cclk_q) begin
        pulses++;
        if (exp_bits.size() == 0) chk(0, "R5", "unexpected cclk pulse", pulses, exp_pulses);
        else begin
          automatic logic e = exp_bits.pop_front();
          chk(cfg_din == e, "R4", "din at cclk rise", cfg_din, e);
        end
      end
      cclk_q = cfg_cclk;
      if (id_valid) begin
        if (exp_id.size() == 0) chk(0, "R10", "unexpected id byte", id_data, 0);
        else begin
          automatic logic [7:0] e = exp_id.pop_front();
          chk(id_data == e, "R10", "id byte", id_data, e);
        end
      end
      if (!cfg_prog_n) begin
        prog_lo++;
        if (done_mode != 1) cfg_done = 1'b0;
      end
      if (done_mode == 0 && exp_pulses > 0 && pulses == exp_pulses) cfg_done = 1'b1;
      if (in_ready && cfg_cclk) chk(0, "R8", "cclk high while waiting", 1, 0);
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == 150000) begin
      chk(0, "WDOG", "watchdog expired", cyc_total, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic build(input int len, input int ff_at, input int name_len, input int date_len);
    for (int i = 0; i < 512; i++)
      img[i] = (ff_at < 0 || i < ff_at) ? 8'(8'h41 + i % 20) : 8'((i * 37 + 11) % 256);
    for (int k = 0; k < name_len; k++) img[16 + k] = 8'(8'h61 + k);
    if (name_len < 12) img[16 + name_len] = 8'h00;
    for (int k = 0; k < date_len; k++) img[44 + k] = 8'(8'h30 + k);
    if (date_len < 10) img[44 + date_len] = 8'h00;
    if (ff_at >= 0) img[ff_at] = 8'hFF;
    img_len = 16'(len);
  endtask

  // driver: computes expectations, runs one load, checks the outcome
  task automatic run_case(input string tag, input int len, input int mode, input bit gap, input bit poke);
    int f = -1, idx = 0, cyc = 0, exp_taken;
    bit named = 0, dated = 0, fire, succ;
    exp_bits.delete(); exp_id.delete();
    for (int i = 0; i < len; i++) if (f < 0 && img[i] == 8'hFF) f = i;
    exp_taken = (mode == 1) ? 0 : len;
    exp_pulses = (mode == 1 || f < 0) ? 0 : 8 * (len - f) + 5;
    succ = (mode == 0 && f >= 0);
    if (exp_pulses > 0) begin
      for (int i = f; i < len; i++)
        for (int b = 7; b >= 0; b--) exp_bits.push_back(img[i][b]);
      for (int t = 0; t < 5; t++) exp_bits.push_back(img[len - 1][0]);
    end
    if (exp_taken > 0) begin
      for (int o = 16; o < 28 && o < len && !named; o++) begin
        if (img[o] == 8'h00) begin exp_id.push_back(8'h20); named = 1; end
        else exp_id.push_back(img[o]);
      end
      if (!named && 28 < len) exp_id.push_back(8'h20);
      for (int o = 44; o < 54 && o < len && !dated; o++) begin
        exp_id.push_back(img[o]);
        if (img[o] == 8'h00) dated = 1;
      end
      if (!dated && 54 < len) exp_id.push_back(8'h00);
    end
    pulses = 0; prog_lo = 0; done_mode = mode; cfg_done = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    chk(!ok && !err, "R9", {tag, " flags cleared by start"}, {ok, err}, 0);
    while (busy) begin
      in_valid = (idx < len) && !(gap && (cyc % 3 == 1));
      in_data  = (idx < len) ? img[idx] : 8'h00;
      start    = poke && (cyc == 40);
      fire     = in_valid && in_ready;
      @(posedge clk);
      if (fire) idx++;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0; start = 1'b0;
    chk(prog_lo == PROG_CYC, "R2", {tag, " program low width"}, prog_lo, PROG_CYC);
    chk(idx == exp_taken, (f < 0 && mode != 1) ? "R7" : "R8", {tag, " bytes taken"}, idx, exp_taken);
    chk(pulses == exp_pulses, (mode == 1) ? "R2" : (f < 0 ? "R7" : "R5"), {tag, " cclk pulses"}, pulses, exp_pulses);
    chk(exp_bits.size() == 0, "R3", {tag, " all bits shifted"}, exp_bits.size(), 0);
    chk(exp_id.size() == 0, "R10", {tag, " all id bytes seen"}, exp_id.size(), 0);
    chk(ok == succ && err == !succ, "R6", {tag, " result flags"}, {ok, err}, {succ, !succ});
    chk(cfg_prog_n && !cfg_cclk && !cfg_din && !in_ready, "R1", {tag, " idle lines"},
        {cfg_prog_n, cfg_cclk, cfg_din, in_ready}, 4'b1000);
    repeat (6) @(negedge clk);
    chk(ok == succ && err == !succ, "R9", {tag, " flags sticky"}, {ok, err}, {succ, !succ});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_prog_n && !cfg_cclk && !cfg_din, "R1", "reset lines", {cfg_prog_n, cfg_cclk, cfg_din}, 3'b100);
    chk(!busy && !ok && !err && !in_ready, "R1", "reset status", {busy, ok, err, in_ready}, 0);
    build(72, 64, 5, 10);  run_case("R3 sync after header",   72, 0, 0, 0);
    build(62, 56, 12, 4);  run_case("R8 stalled, late start", 62, 0, 1, 1);
    build(80, 60, 3, 3);   run_case("R2 done stuck high",     80, 1, 0, 0);
    build(60, -1, 6, 7);   run_case("R7 no sync byte",        60, 0, 1, 0);
    build(66, 64, 12, 10); run_case("R6 done never rises",    66, 2, 0, 0);
    build(6, 0, 0, 0);     run_case("R3 sync at offset zero",  6, 0, 0, 0);
    build(48, 18, 8, 10);  run_case("R10 sync in name field", 48, 0, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule